// File: doc/BRIEF.md
# Switch Power-Up Reset and Default Configuration Sequencer

This block brings an attached Ethernet switch chip out of reset and loads a default configuration into it. On a start pulse it runs a three-phase timed pulse on the chip's reset control line. The phases are a high hold, a long low hold and a final high hold. During the final phase it drives the serial clock and data pins to fixed strap levels. Afterwards it releases those pins so the serial master can use them.

Next it asks the serial master to read register 0 of the chip. This is the presence probe. A value of all zeros or all ones means that no chip answered. In that case the block raises an error flag, skips the configuration and reports completion.

When a chip is present, the block hands a fixed list of seven register writes to the write port of the serial master, one at a time. Each write uses a request/done handshake. All timing is counted in milliseconds. A tick generator divides the system clock down to one tick per millisecond.

Top module: `switch_boot_sequencer`

## Requirements
- R1: After reset, `rst_line_o` is high and `pin_oe_o`, `probe_req_o`, `wr_req_o`, `busy_o`, `complete_o` and `chip_absent_o` are all low.
- R2: A start pulse accepted at a clock edge keeps `rst_line_o` high for exactly HOLD_HI_MS*CLKS_PER_MS cycles from that edge. It then drives it low for exactly HOLD_LO_MS*CLKS_PER_MS cycles, then high again. `rst_line_o` stays high from then on.
- R3: For exactly STRAP_MS*CLKS_PER_MS cycles after the low phase, `pin_oe_o` is 1 with `pin_sclk_o`=1 and `pin_sdat_o`=0. At every other time `pin_oe_o` is 0.
- R4: In the cycle after the strap phase ends, `probe_req_o` rises. It stays high until `probe_done_i` is sampled high, and no write is requested while it is high.
- R5: A probe value of 16'h0000 or 16'hFFFF sets `chip_absent_o` and `complete_o` in the cycle after `probe_done_i`, and no write is ever requested in that run.
- R6: Any other probe value starts seven writes, in this order of `wr_addr_o`: 8'h01, 8'h03, 8'h05, 8'h07, 8'h08, 8'h09, 8'h11.
- R7: `wr_data_o` is 16'h800F for the first five writes, 16'h801F (tag bit 4 added) for address 8'h09, and 16'hFF30 for address 8'h11.
- R8: `wr_req_o` stays high with stable `wr_addr_o`/`wr_data_o` until `wr_done_i` is sampled high. It is then low for at least one cycle, and the next write is requested only after that.
- R9: `complete_o` rises in the cycle after the last write's done and holds until the next accepted start. `busy_o` is high from the accepted start until completion.
- R10: A start pulse while `busy_o` is high is ignored: the phase lengths and the write list are unchanged.
- R11: A start accepted after completion clears `complete_o` and `chip_absent_o` and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| rst_line_o | output | 1 | Reset control line to the switch chip (low = held in reset) |
| pin_oe_o | output | 1 | Output enable for the serial clock and data pins |
| pin_sclk_o | output | 1 | Strap level for the serial clock pin |
| pin_sdat_o | output | 1 | Strap level for the serial data pin |
| probe_req_o | output | 1 | Request to read register 0 |
| probe_data_i | input | 16 | Value returned by the probe read |
| probe_done_i | input | 1 | Probe read finished, data valid |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | 8 | Register write address |
| wr_data_o | output | 16 | Register write data |
| wr_done_i | input | 1 | Register write finished |
| busy_o | output | 1 | Sequence in progress |
| complete_o | output | 1 | Sequence finished |
| chip_absent_o | output | 1 | Probe found no chip |

## Verification
A tick counter that slips by even one cycle shows up in every phase at once. Each measured hold length on `rst_line_o` or `pin_oe_o` is then off by a multiple of the slip, and this is visible within the first reset phase. A walker index that skips or repeats an entry shows up at the very next write request as a wrong address/data pair. An early or missing completion shows up in the cycle after the final done. A wrong presence decision shows up in the cycle after the probe done, as a write request where none should be or a missing one.

// File: rtl/swboot_pkg.sv
package swboot_pkg;
  localparam int unsigned BOOT_WRITES = 7;
  localparam int unsigned IDX_W       = $clog2(BOOT_WRITES);
  localparam int unsigned TAG_PORT    = 5;

  typedef enum logic [1:0] {PH_OFF, PH_HOLD_HI, PH_HOLD_LO, PH_STRAP} rst_phase_e;
  typedef enum logic [2:0] {ST_IDLE, ST_PULSE, ST_PROBE, ST_WRITE, ST_DONE} top_state_e;

  // Address of the idx-th default write: six port registers, then mode register
  function automatic logic [7:0] boot_addr(input logic [IDX_W-1:0] idx);
    logic [7:0] a;
    case (idx)
      3'd0:    a = 8'h01;
      3'd1:    a = 8'h03;
      3'd2:    a = 8'h05;
      3'd3:    a = 8'h07;
      3'd4:    a = 8'h08;
      3'd5:    a = 8'h09;
      default: a = 8'h11;
    endcase
    return a;
  endfunction

  // Data of the idx-th default write
  function automatic logic [15:0] boot_data(input logic [IDX_W-1:0] idx);
    logic [15:0] d;
    if (idx == IDX_W'(BOOT_WRITES - 1)) d = 16'hFF30;
    else begin
      d = 16'h800F;
      if (idx == IDX_W'(TAG_PORT)) d = d | 16'h0010;
    end
    return d;
  endfunction

  function automatic logic chip_missing(input logic [15:0] v);
    return (v == 16'h0000) || (v == 16'hFFFF);
  endfunction
endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int unsigned CLKS_PER_MS = 125000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] LIM = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0] cyc_q;

  assign tick_o = en_i && (cyc_q == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n)      cyc_q <= '0;
    else if (!en_i)  cyc_q <= '0;
    else if (tick_o) cyc_q <= '0;
    else             cyc_q <= cyc_q + 1'b1;
  end

  generate
    if (CLKS_PER_MS > 1) begin : g_gap
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R2
    end
  endgenerate
  AST_CYC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q <= LIM); // R2
endmodule

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl
  import swboot_pkg::*;
#(
  parameter int unsigned HOLD_HI_MS = 20,
  parameter int unsigned HOLD_LO_MS = 100,
  parameter int unsigned STRAP_MS   = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_i,
  input  logic       tick_i,
  output rst_phase_e phase_o,
  output logic       active_o,
  output logic       fin_o
);
  localparam int unsigned MAX_A = (HOLD_HI_MS > HOLD_LO_MS) ? HOLD_HI_MS : HOLD_LO_MS;
  localparam int unsigned MAXMS = (MAX_A > STRAP_MS) ? MAX_A : STRAP_MS;
  localparam int unsigned MW    = (MAXMS > 1) ? $clog2(MAXMS) : 1;

  rst_phase_e  phase_q;
  logic [MW-1:0] ms_q;
  logic [MW-1:0] cur_lim;
  logic          last_ms;

  always_comb begin
    case (phase_q)
      PH_HOLD_HI: cur_lim = MW'(HOLD_HI_MS - 1);
      PH_HOLD_LO: cur_lim = MW'(HOLD_LO_MS - 1);
      PH_STRAP:   cur_lim = MW'(STRAP_MS - 1);
      default:    cur_lim = '0;
    endcase
    last_ms = tick_i && (ms_q == cur_lim);
  end

  assign phase_o  = phase_q;
  assign active_o = (phase_q != PH_OFF);
  assign fin_o    = (phase_q == PH_STRAP) && last_ms;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      ms_q    <= '0;
    end else if (phase_q == PH_OFF) begin
      if (launch_i) phase_q <= PH_HOLD_HI;
      ms_q <= '0;
    end else if (last_ms) begin
      ms_q <= '0;
      case (phase_q)
        PH_HOLD_HI: phase_q <= PH_HOLD_LO;
        PH_HOLD_LO: phase_q <= PH_STRAP;
        default:    phase_q <= PH_OFF;
      endcase
    end else if (tick_i) begin
      ms_q <= ms_q + 1'b1;
    end
  end

  AST_MS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> (ms_q <= cur_lim)); // R2
  AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD_HI) |=> (phase_q inside {PH_HOLD_HI, PH_HOLD_LO})); // R2
  AST_LO_THEN_STRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD_LO) |=> (phase_q inside {PH_HOLD_LO, PH_STRAP})); // R3
endmodule

// File: rtl/boot_write_seq.sv
module boot_write_seq
  import swboot_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch_i,
  input  logic        wr_done_i,
  output logic        wr_req_o,
  output logic [7:0]  wr_addr_o,
  output logic [15:0] wr_data_o,
  output logic        fin_o
);
  logic             req_q;
  logic             gap_q;
  logic [IDX_W-1:0] idx_q;
  logic             last_entry;
  logic             accepted;

  assign last_entry = (idx_q == IDX_W'(BOOT_WRITES - 1));
  assign accepted   = req_q && wr_done_i;
  assign fin_o      = accepted && last_entry;
  assign wr_req_o   = req_q;
  assign wr_addr_o  = boot_addr(idx_q);
  assign wr_data_o  = boot_data(idx_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      gap_q <= 1'b0;
      idx_q <= '0;
    end else if (launch_i) begin
      req_q <= 1'b1;
      gap_q <= 1'b0;
      idx_q <= '0;
    end else if (accepted) begin
      req_q <= 1'b0;
      if (!last_entry) begin
        gap_q <= 1'b1;
        idx_q <= idx_q + 1'b1;
      end
    end else if (gap_q) begin
      gap_q <= 1'b0;
      req_q <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !wr_done_i) |=> (req_q && $stable(wr_addr_o) && $stable(wr_data_o))); // R8
  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> !req_q); // R8
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(BOOT_WRITES)); // R6
endmodule

// File: rtl/switch_boot_sequencer.sv
module switch_boot_sequencer
  import swboot_pkg::*;
#(
  parameter int unsigned CLKS_PER_MS = 125000,
  parameter int unsigned HOLD_HI_MS  = 20,
  parameter int unsigned HOLD_LO_MS  = 100,
  parameter int unsigned STRAP_MS    = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  output logic        rst_line_o,
  output logic        pin_oe_o,
  output logic        pin_sclk_o,
  output logic        pin_sdat_o,
  output logic        probe_req_o,
  input  logic [15:0] probe_data_i,
  input  logic        probe_done_i,
  output logic        wr_req_o,
  output logic [7:0]  wr_addr_o,
  output logic [15:0] wr_data_o,
  input  logic        wr_done_i,
  output logic        busy_o,
  output logic        complete_o,
  output logic        chip_absent_o
);
  top_state_e state_q;
  rst_phase_e phase;
  logic       ms_tick;
  logic       pulse_active;
  logic       pulse_fin;
  logic       pulse_launch;
  logic       wr_launch;
  logic       wr_fin;
  logic       probe_hit;
  logic       complete_q;
  logic       absent_q;

  assign pulse_launch = start_i && (state_q inside {ST_IDLE, ST_DONE});
  assign probe_hit    = (state_q == ST_PROBE) && probe_done_i;
  assign wr_launch    = probe_hit && !chip_missing(probe_data_i);

  ms_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(pulse_active), .tick_o(ms_tick)
  );

  rst_pulse_ctrl #(
    .HOLD_HI_MS(HOLD_HI_MS), .HOLD_LO_MS(HOLD_LO_MS), .STRAP_MS(STRAP_MS)
  ) u_pulse (
    .clk(clk), .rst_n(rst_n), .launch_i(pulse_launch), .tick_i(ms_tick),
    .phase_o(phase), .active_o(pulse_active), .fin_o(pulse_fin)
  );

  boot_write_seq u_writer (
    .clk(clk), .rst_n(rst_n), .launch_i(wr_launch), .wr_done_i(wr_done_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .fin_o(wr_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      complete_q <= 1'b0;
      absent_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (pulse_launch) begin
          state_q    <= ST_PULSE;
          complete_q <= 1'b0;
          absent_q   <= 1'b0;
        end
        ST_PULSE: if (pulse_fin) state_q <= ST_PROBE;
        ST_PROBE: if (probe_hit) begin
          if (wr_launch) state_q <= ST_WRITE;
          else begin
            state_q    <= ST_DONE;
            absent_q   <= 1'b1;
            complete_q <= 1'b1;
          end
        end
        ST_WRITE: if (wr_fin) begin
          state_q    <= ST_DONE;
          complete_q <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rst_line_o    = (phase != PH_HOLD_LO);
  assign pin_oe_o      = (phase == PH_STRAP);
  assign pin_sclk_o    = (phase == PH_STRAP);
  assign pin_sdat_o    = 1'b0;
  assign probe_req_o   = (state_q == ST_PROBE);
  assign busy_o        = state_q inside {ST_PULSE, ST_PROBE, ST_WRITE};
  assign complete_o    = complete_q;
  assign chip_absent_o = absent_q;

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(probe_req_o && wr_req_o)); // R4
  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chip_absent_o |-> !wr_req_o); // R5
  AST_STRAP_RST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe_o |-> rst_line_o); // R3
  AST_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_line_o |-> busy_o); // R2
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |-> !busy_o); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && (phase == PH_HOLD_LO)) |=> (phase inside {PH_HOLD_LO, PH_STRAP})); // R10
endmodule

// File: tb/switch_boot_sequencer_bench.sv
module switch_boot_sequencer_bench;
  localparam int DIV = 4;
  localparam int HI  = 3;
  localparam int LO  = 5;
  localparam int SP  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        rst_line_o, pin_oe_o, pin_sclk_o, pin_sdat_o;
  logic        probe_req_o;
  logic [15:0] probe_data_i = 16'h0;
  logic        probe_done_i = 1'b0;
  logic        wr_req_o;
  logic [7:0]  wr_addr_o;
  logic [15:0] wr_data_o;
  logic        wr_done_i = 1'b0;
  logic        busy_o, complete_o, chip_absent_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  switch_boot_sequencer #(
    .CLKS_PER_MS(DIV), .HOLD_HI_MS(HI), .HOLD_LO_MS(LO), .STRAP_MS(SP)
  ) u_switch_boot_sequencer (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 20000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int k);
    if (k == 6) return 'h11;
    if (k < 4)  return 2 * k + 1;
    return k + 4;
  endfunction

  function automatic int exp_data(input int k);
    if (k == 6) return 'hFF30;
    return (k == 5) ? 'h801F : 'h800F;
  endfunction

  task automatic run(input logic [15:0] pv, input int lat, input bit poke);
    int hi, lo, sp, w;
    bit oe_bad, strap_bad;
    hi = 0; lo = 0; sp = 0; oe_bad = 0; strap_bad = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
    chk(complete_o == 1'b0 && chip_absent_o == 1'b0, "R11 flags cleared", {complete_o, chip_absent_o}, 0);
    while (rst_line_o && hi < 1000) begin
      if (pin_oe_o) oe_bad = 1;
      hi++;
      @(negedge clk);
    end
    chk(hi == HI * DIV, "R2 first high length", hi, HI * DIV);
    while (!rst_line_o && lo < 1000) begin
      if (pin_oe_o) oe_bad = 1;
      if (poke) start_i = (lo == 2);
      lo++;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(lo == LO * DIV, "R2 low length (R10 start ignored when poked)", lo, LO * DIV);
    chk(!oe_bad, "R3 pins undriven before strap", oe_bad, 0);
    while (pin_oe_o && sp < 1000) begin
      if (!(pin_sclk_o == 1'b1 && pin_sdat_o == 1'b0 && rst_line_o == 1'b1)) strap_bad = 1;
      sp++;
      @(negedge clk);
    end
    chk(sp == SP * DIV, "R3 strap length", sp, SP * DIV);
    chk(!strap_bad, "R3 strap levels", strap_bad, 0);
    chk(probe_req_o == 1'b1 && wr_req_o == 1'b0, "R4 probe request", {probe_req_o, wr_req_o}, 2);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(probe_req_o == 1'b1 && rst_line_o == 1'b1, "R4 probe held", probe_req_o, 1);
    end
    probe_data_i = pv;
    probe_done_i = 1'b1;
    @(negedge clk);
    probe_done_i = 1'b0;
    chk(probe_req_o == 1'b0, "R4 probe released", probe_req_o, 0);
    if (pv == 16'h0000 || pv == 16'hFFFF) begin
      chk(chip_absent_o == 1'b1 && complete_o == 1'b1, "R5 absent and complete", {chip_absent_o, complete_o}, 3);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(wr_req_o == 1'b0, "R5 no write when absent", wr_req_o, 0);
      end
    end else begin
      for (int k = 0; k < 7; k++) begin
        w = 0;
        while (!wr_req_o && w < 10) begin
          w++;
          @(negedge clk);
        end
        chk(wr_addr_o == exp_addr(k), "R6 write address", wr_addr_o, exp_addr(k));
        chk(wr_data_o == exp_data(k), "R7 write data", wr_data_o, exp_data(k));
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk(wr_req_o && wr_addr_o == exp_addr(k) && wr_data_o == exp_data(k),
              "R8 request held stable", wr_addr_o, exp_addr(k));
        end
        chk(complete_o == 1'b0, "R9 not complete mid-list", complete_o, 0);
        wr_done_i = 1'b1;
        @(negedge clk);
        wr_done_i = 1'b0;
        chk(wr_req_o == 1'b0, "R8 request dropped after done", wr_req_o, 0);
      end
      chk(complete_o == 1'b1 && busy_o == 1'b0, "R9 complete after last write", {complete_o, busy_o}, 2);
      chk(chip_absent_o == 1'b0, "R6 chip present flag", chip_absent_o, 0);
      repeat (3) @(negedge clk);
      chk(complete_o == 1'b1 && wr_req_o == 1'b0, "R9 complete holds", complete_o, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rst_line_o == 1'b1 && pin_oe_o == 1'b0 && probe_req_o == 1'b0 && wr_req_o == 1'b0 &&
        busy_o == 1'b0 && complete_o == 1'b0 && chip_absent_o == 1'b0,
        "R1 reset state", {rst_line_o, pin_oe_o, busy_o, complete_o}, 8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o == 1'b0 && rst_line_o == 1'b1, "R1 idle after reset", busy_o, 0);
    run(16'h1234, 0, 1'b0);
    run(16'h0000, 1, 1'b1);
    run(16'h0001, 2, 1'b0);
    run(16'hFFFF, 0, 1'b0);
    run(16'hFFFE, 3, 1'b1);
    run(16'h8000, 1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule